// File: doc/BRIEF.md
# Four-Pin GPIO Port with External Bus Strobe Override

This block is a four-pin bidirectional general-purpose port. Each pin has an output latch bit and a direction bit. Software reaches both through a small synchronous register interface with an 8-bit data path. A direction bit of 1 turns the pin's driver off, so the pin is an input. A direction bit of 0 makes the pin drive its latch bit. A read of the data address returns the synchronized pin levels, not the latch.

A two-bit operating-mode input decides who owns the lower three pins. In the two bus-capable modes, those pins carry the strobes of an external multiplexed address/data bus. The strobes come from a separate bus controller, and the direction register has no effect on those pins while the mode holds. The top pin is general purpose in every mode. The latch and direction registers keep their values across mode changes, so GPIO behaviour resumes as soon as a non-bus mode returns.

Top module: `gpio4_busmux`

## Requirements
- R1: After reset, all four direction bits are 1 (a direction read returns 0x0F), all latch bits are 0, and in a non-bus mode no pin is driven (`pin_oe` = 0).
- R2: For a pin under GPIO control, direction bit 1 gives `pin_oe` low. Direction bit 0 gives `pin_oe` high with `pin_out` equal to that pin's latch bit.
- R3: A write with `reg_addr`=0 changes only the latch, and the new value is visible on `pin_out` of output pins from the next cycle. The direction bits are unchanged.
- R4: A read with `reg_addr`=0 returns `pin_in` in bits 3:0 through a two-flop synchronizer. A pin change driven before a clock edge appears after the second edge, whatever the latch holds.
- R5: Bits 7:4 of `reg_rdata` are always 0 for both addresses.
- R6: With `mode[1]`=1 (modes 2 and 3), pins 0, 1 and 2 are driven (`pin_oe`=1) with address latch enable, active-low output enable and active-low write, in that pin order. This holds whatever the direction register contains.
- R7: Pin 3 follows its direction and latch bits in all four modes.
- R8: Latch writes made while bus mode owns pins 2:0 are stored, and they appear on those pins once `mode[1]` returns to 0.
- R9: The latch keeps its value when direction bits change. A write with `reg_addr`=1 stores `reg_wdata[3:0]` as the direction, and a direction read returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 2 | Operating mode; bit 1 set selects a bus mode |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = pin data/latch, 1 = direction |
| reg_wdata | input | 8 | Write data; bits 3:0 used |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| bus_ale | input | 1 | Address latch enable from bus controller (active high) |
| bus_oe_n | input | 1 | Output enable strobe from bus controller (active low) |
| bus_wr_n | input | 1 | Write strobe from bus controller (active low) |
| pin_in | input | 4 | Pad input levels |
| pin_out | output | 4 | Pad output values |
| pin_oe | output | 4 | Pad driver enables (1 = drive) |

## Verification
The hardest case to reach from the ports is the one where a latch value written during bus mode must reappear later. The bench first clears direction bits on pins 2:0 to make them outputs, then enters a bus mode. While the strobes are driven to values that differ from the latch, it writes a new latch pattern. It then returns to a non-bus mode and checks that `pin_out` shows the pattern written during bus ownership. The bench also compares `pin_in` readback against a latch value that differs from it, to show that a read returns the pin levels rather than the latch.

// File: rtl/gpio4_pkg.sv
package gpio4_pkg;
  localparam int unsigned PORT_W   = 4;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned CTL_PINS = 3;
  localparam int unsigned SYNC_N   = 2;
  localparam logic [PORT_W-1:0] DIR_RST = '1;
endpackage

// File: rtl/gpio4_regs.sv
module gpio4_regs #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] DIR_INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wen,
  input  logic         addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q
);
  logic [W-1:0] latch_d, dir_d;
  logic         latch_en, dir_en;

  always_comb begin
    latch_en = wen & ~addr;
    dir_en   = wen &  addr;
    latch_d  = latch_en ? wdata : latch_q;
    dir_d    = dir_en   ? wdata : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= DIR_INIT;
    end else begin
      latch_q <= latch_d;
      dir_q   <= dir_d;
    end
  end
endmodule

// File: rtl/gpio4_sync.sv
module gpio4_sync #(
  parameter int unsigned W = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stg_d[s] = d;
      end else begin : g_next
        assign stg_d[s] = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d[s];
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio4_padmux.sv
module gpio4_padmux #(
  parameter int unsigned W = 4,
  parameter int unsigned CTL = 3
) (
  input  logic           bus_own,
  input  logic [CTL-1:0] ctl,
  input  logic [W-1:0]   latch_q,
  input  logic [W-1:0]   dir_q,
  output logic [W-1:0]   pin_out,
  output logic [W-1:0]   pin_oe
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      if (i < CTL) begin : g_shared
        always_comb begin
          if (bus_own) begin
            pin_out[i] = ctl[i];
            pin_oe[i]  = 1'b1;
          end else begin
            pin_out[i] = latch_q[i];
            pin_oe[i]  = ~dir_q[i];
          end
        end
      end else begin : g_gpio
        always_comb begin
          pin_out[i] = latch_q[i];
          pin_oe[i]  = ~dir_q[i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/gpio4_busmux.sv
module gpio4_busmux
  import gpio4_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              reg_wen,
  input  logic              reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              bus_ale,
  input  logic              bus_oe_n,
  input  logic              bus_wr_n,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);
  localparam int unsigned PAD_W = REG_W - PORT_W;

  logic              rst_m, rst_s;
  logic [PORT_W-1:0] latch_q, dir_q, pin_sync;
  logic [CTL_PINS-1:0] ctl;
  logic              bus_own;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  gpio4_regs #(.W(PORT_W), .DIR_INIT(DIR_RST)) i_regs (
    .clk(clk), .rst_n(rst_s), .wen(reg_wen), .addr(reg_addr),
    .wdata(reg_wdata[PORT_W-1:0]), .latch_q(latch_q), .dir_q(dir_q)
  );

  gpio4_sync #(.W(PORT_W), .STAGES(SYNC_N)) i_sync (
    .clk(clk), .rst_n(rst_s), .d(pin_in), .q(pin_sync)
  );

  assign bus_own = mode[1];
  assign ctl     = {bus_wr_n, bus_oe_n, bus_ale};

  gpio4_padmux #(.W(PORT_W), .CTL(CTL_PINS)) i_padmux (
    .bus_own(bus_own), .ctl(ctl), .latch_q(latch_q), .dir_q(dir_q),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always_comb begin
    if (reg_addr) reg_rdata = {{PAD_W{1'b0}}, dir_q};
    else          reg_rdata = {{PAD_W{1'b0}}, pin_sync};
  end
endmodule

// File: rtl/gpio4_busmux_chk.sv
module gpio4_busmux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       reg_wen,
  input logic       reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       bus_ale,
  input logic       bus_oe_n,
  input logic       bus_wr_n,
  input logic [3:0] pin_in,
  input logic [3:0] pin_out,
  input logic [3:0] pin_oe
);
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:4] == 4'h0);

  a_r6_bus_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |-> (pin_oe[2:0] == 3'b111 && pin_out[0] == bus_ale &&
                 pin_out[1] == bus_oe_n && pin_out[2] == bus_wr_n));

  a_r2_dir_input: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && reg_wen && reg_addr && reg_wdata[3]) |=> !pin_oe[3]);

  a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && !(reg_wen && !reg_addr)) |=> $stable(pin_out[3]));

  a_r4_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd5 && !reg_addr) |-> reg_rdata[3:0] == $past(pin_in, 2));
endmodule

bind gpio4_busmux gpio4_busmux_chk i_chk (.*);

// File: tb/test_gpio4_busmux.sv
`timescale 1ns/1ps
module test_gpio4_busmux;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       reg_wen, reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       bus_ale, bus_oe_n, bus_wr_n;
  logic [3:0] pin_in, pin_out, pin_oe;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio4_busmux i_gpio4_busmux (
    .clk(clk), .rst_n(rst_n), .mode(mode), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_ale(bus_ale),
    .bus_oe_n(bus_oe_n), .bus_wr_n(bus_wr_n), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b1, v);
    chk("R1 dir", v, 8'h0F);
    chk("R1 oe", {4'h0, pin_oe}, 8'h00);
    chk("R1 latch", {4'h0, pin_out}, 8'h00);
  endtask

  task automatic t_gpio_dir();
    logic [7:0] v;
    wr(1'b0, 8'h0A);
    chk("R2 still input", {4'h0, pin_oe}, 8'h00);
    wr(1'b1, 8'hF3);
    chk("R2 oe", {4'h0, pin_oe}, 8'h0C);
    chk("R3 pin_out", {4'h0, pin_out & pin_oe}, 8'h08);
    rd(1'b1, v);
    chk("R9 dir read", v, 8'h03);
    wr(1'b0, 8'h05);
    rd(1'b1, v);
    chk("R3 dir untouched", v, 8'h03);
    chk("R3 latch out", {4'h0, pin_out & pin_oe}, 8'h04);
  endtask

  task automatic t_readback();
    logic [7:0] v;
    @(negedge clk); pin_in = 4'hB;
    @(negedge clk);
    rd(1'b0, v);
    chk("R4 one edge old", v, 8'h06);
    @(negedge clk);
    rd(1'b0, v);
    chk("R4 pins not latch", v, 8'h0B);
    chk("R5 upper zero", {v[7:4], 4'h0}, 8'h00);
  endtask

  task automatic t_upper();
    logic [7:0] v;
    wr(1'b1, 8'hA6);
    rd(1'b1, v);
    chk("R5 dir upper", v, 8'h06);
    chk("R2 oe from dir", {4'h0, pin_oe}, 8'h09);
  endtask

  task automatic t_bus_mode();
    wr(1'b1, 8'h0F);
    wr(1'b0, 8'h08);
    for (int m = 2; m < 4; m++) begin
      @(negedge clk);
      mode = m[1:0]; bus_ale = 1'b1; bus_oe_n = 1'b0; bus_wr_n = 1'b1;
      #0.5;
      chk("R6 oe", {4'h0, pin_oe}, 8'h07);
      chk("R6 strobes", {5'h0, pin_out[2:0]}, 8'h05);
      chk("R7 pin3 input", {7'h0, pin_oe[3]}, 8'h00);
    end
    wr(1'b1, 8'h07);
    chk("R7 pin3 out in bus", {6'h0, pin_oe[3], pin_out[3]}, 8'h03);
    mode = 2'b01;
    #0.5;
    chk("R7 mode1", {4'h0, pin_oe}, 8'h08);
  endtask

  task automatic t_latch_in_bus();
    wr(1'b1, 8'h08);
    wr(1'b0, 8'h00);
    @(negedge clk);
    mode = 2'b10; bus_ale = 1'b0; bus_oe_n = 1'b0; bus_wr_n = 1'b0;
    wr(1'b0, 8'h07);
    #0.5;
    chk("R8 still bus", {5'h0, pin_out[2:0]}, 8'h00);
    @(negedge clk);
    mode = 2'b00;
    #0.5;
    chk("R8 oe back", {4'h0, pin_oe}, 8'h07);
    chk("R8 latch shown", {5'h0, pin_out[2:0]}, 8'h07);
  endtask

  task automatic t_latch_keep();
    wr(1'b1, 8'h0F);
    wr(1'b1, 8'h00);
    chk("R9 latch kept", {4'h0, pin_out}, 8'h07);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'b00; reg_wen = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    bus_ale = 1'b0; bus_oe_n = 1'b1; bus_wr_n = 1'b1; pin_in = 4'h6;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_gpio_dir();
    t_readback();
    t_upper();
    t_bus_mode();
    t_latch_in_bus();
    t_latch_keep();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule